// File: doc/BRIEF.md
# Threshold-Flagged Audio Sample FIFO

This block is an eight-entry word buffer placed between a serial audio engine and a data register port. Each entry holds one right-aligned audio sample word, and every port access, whatever its width on the bus side, moves exactly one entry. The oldest stored word is always presented on the read data output, so a read strobe consumes the word already visible.

The buffer publishes a coarse 3-bit fill code and compares it against a programmable 3-bit threshold code. The result is a live request flag that needs no acknowledge: it rises and falls purely with the fill code. The same flag drives an interrupt output gated by an interrupt enable and a DMA request output gated by a DMA enable. A flush input empties the buffer at once and discards whatever it held.

Occupancy is tracked by a three-state machine: ST_EMPTY, ST_PARTIAL and ST_FULL. Its transitions are: FILL_START (ST_EMPTY to ST_PARTIAL on an accepted write), FILL_TOP (ST_PARTIAL to ST_FULL when the count reaches the depth), DRAIN_TOP (ST_FULL to ST_PARTIAL on a read with no write), DRAIN_LAST (ST_PARTIAL to ST_EMPTY when the last word leaves) and FLUSH_ALL (any state to ST_EMPTY on flush).

Top module: `audio_sample_fifo`

## Requirements
- R1: Words leave in the order they were written, up to 8 stored words, and rd_data shows the oldest stored word whenever the buffer is not empty.
- R2: Each accepted write adds one entry and each accepted read removes one; a write and a read in the same cycle on a non-empty buffer leave the count unchanged.
- R3: level_code encodes the count as 000 empty, 001 one word, 010 two or three, 011 four or five, 100 six or seven, 101 eight (full), and is updated in the cycle after the access edge.
- R4: req_flag is high with thresh_code 000 when level_code is 000, with 001 when level_code is 010 or more, with 010 when it is 011 or more, with 011 when it is 100 or more, and with 100 only when it is 101; it follows threshold and level changes with no acknowledge.
- R5: thresh_code values 101, 110 and 111 never raise req_flag.
- R6: irq equals req_flag while irq_en is 1 and is 0 otherwise; dma_req equals req_flag while dma_en is 1 and is 0 otherwise.
- R7: A write to a full buffer without a simultaneous read is ignored, leaves stored data intact, and gives a single-cycle overrun pulse in the cycle after the edge; a write with a read on a full buffer is accepted.
- R8: A read from an empty buffer is ignored and gives a single-cycle underrun pulse in the cycle after the edge; a write in that same cycle is still stored.
- R9: flush empties the buffer and resets both pointers, overriding any write or read in the same cycle, and produces no overrun or underrun pulse for that cycle.
- R10: After reset the buffer is empty, level_code is 000 and overrun and underrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the buffer and resets the pointers |
| wr_en | input | 1 | Write strobe, one entry per cycle |
| wr_data | input | DATA_W | Sample word to store |
| rd_en | input | 1 | Read strobe, consumes the word on rd_data |
| rd_data | output | DATA_W | Oldest stored word |
| thresh_code | input | 3 | Request threshold code |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA enable |
| level_code | output | 3 | Coarse fill code |
| req_flag | output | 1 | Live threshold request |
| irq | output | 1 | Gated interrupt request |
| dma_req | output | 1 | Gated DMA request |
| overrun | output | 1 | Pulse: write refused while full |
| underrun | output | 1 | Pulse: read refused while empty |

## Verification
The bench walks the count up through every fill code and back down while moving the threshold, so a fill code boundary placed one word off, or a threshold compare using the wrong inequality, shows up as a wrong request at a single step. It writes into a full buffer and then reads all eight words back, catching a design that overwrites the oldest entry or forgets to pulse overrun, and it reads an empty buffer while writing to catch one that drops the write along with the refused read. A flush applied together with a write checks that the flush wins and the pointers restart, and the reserved threshold codes and both enables are toggled to expose a request that leaks past its gating.

// File: rtl/asf_pkg.sv
package asf_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

    localparam logic [2:0] LVL_EMPTY = 3'd0;
    localparam logic [2:0] LVL_ONE   = 3'd1;
    localparam logic [2:0] LVL_Q1    = 3'd2;
    localparam logic [2:0] LVL_Q2    = 3'd3;
    localparam logic [2:0] LVL_Q3    = 3'd4;
    localparam logic [2:0] LVL_FULL  = 3'd5;

    localparam logic [2:0] TH_EMPTY   = 3'd0;
    localparam logic [2:0] TH_QUARTER = 3'd1;
    localparam logic [2:0] TH_HALF    = 3'd2;
    localparam logic [2:0] TH_3QUART  = 3'd3;
    localparam logic [2:0] TH_FULL    = 3'd4;

endpackage

// File: rtl/asf_ctrl.sv
module asf_ctrl
    import asf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             wr_go,
    output logic             rd_go,
    output logic [CNT_W-1:0] count,
    output logic             overrun,
    output logic             underrun
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEPTH);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_d;

    // Acceptance: a read needs data; a write needs room or a paired read.
    always_comb begin
        rd_go = rd_en && !flush && (state_q != ST_EMPTY);
        wr_go = wr_en && !flush && ((state_q != ST_FULL) || rd_go);
        if (flush) begin
            count_d = '0;
        end else begin
            count_d = count + CNT_W'(wr_go) - CNT_W'(rd_go);
        end
    end

    // Transition selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_go) begin
                    state_d = ST_PARTIAL;          // FILL_START
                end
            end
            ST_PARTIAL: begin
                if (flush || (count_d == '0)) begin
                    state_d = ST_EMPTY;            // FLUSH_ALL / DRAIN_LAST
                end else if (count_d == CNT_TOP) begin
                    state_d = ST_FULL;             // FILL_TOP
                end
            end
            ST_FULL: begin
                if (flush) begin
                    state_d = ST_EMPTY;            // FLUSH_ALL
                end else if (rd_go && !wr_go) begin
                    state_d = ST_PARTIAL;          // DRAIN_TOP
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs: count and error pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            count    <= count_d;
            overrun  <= wr_en && !flush && !wr_go;
            underrun <= rd_en && !flush && !rd_go;
        end
    end

endmodule

// File: rtl/asf_store.sv
module asf_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_go) wr_ptr <= bump(wr_ptr);
            if (rd_go) rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/asf_level.sv
module asf_level
    import asf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    output logic [2:0]       level_code
);

    localparam logic [CNT_W-1:0] B_Q1  = CNT_W'(DEPTH / 4);
    localparam logic [CNT_W-1:0] B_Q2  = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] B_Q3  = CNT_W'((3 * DEPTH) / 4);
    localparam logic [CNT_W-1:0] B_TOP = CNT_W'(DEPTH);

    always_comb begin
        if (count == '0)         level_code = LVL_EMPTY;
        else if (count >= B_TOP) level_code = LVL_FULL;
        else if (count >= B_Q3)  level_code = LVL_Q3;
        else if (count >= B_Q2)  level_code = LVL_Q2;
        else if (count >= B_Q1)  level_code = LVL_Q1;
        else                     level_code = LVL_ONE;
    end

endmodule

// File: rtl/asf_req.sv
module asf_req
    import asf_pkg::*;
(
    input  logic [2:0] level_code,
    input  logic [2:0] thresh_code,
    input  logic       irq_en,
    input  logic       dma_en,
    output logic       req_flag,
    output logic       irq,
    output logic       dma_req
);

    always_comb begin
        case (thresh_code)
            TH_EMPTY:   req_flag = (level_code == LVL_EMPTY);
            TH_QUARTER: req_flag = (level_code >= LVL_Q1);
            TH_HALF:    req_flag = (level_code >= LVL_Q2);
            TH_3QUART:  req_flag = (level_code >= LVL_Q3);
            TH_FULL:    req_flag = (level_code == LVL_FULL);
            default:    req_flag = 1'b0;
        endcase
        irq     = req_flag && irq_en;
        dma_req = req_flag && dma_en;
    end

endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [2:0]        thresh_code,
    input  logic              irq_en,
    input  logic              dma_en,
    output logic [2:0]        level_code,
    output logic              req_flag,
    output logic              irq,
    output logic              dma_req,
    output logic              overrun,
    output logic              underrun
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    logic             wr_go, rd_go;
    logic [CNT_W-1:0] count;

    asf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .count    (count),
        .overrun  (overrun),
        .underrun (underrun)
    );

    asf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_go   (wr_go),
        .rd_go   (rd_go),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    asf_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
        .count      (count),
        .level_code (level_code)
    );

    asf_req u_req (
        .level_code  (level_code),
        .thresh_code (thresh_code),
        .irq_en      (irq_en),
        .dma_en      (dma_en),
        .req_flag    (req_flag),
        .irq         (irq),
        .dma_req     (dma_req)
    );

endmodule

// File: rtl/asf_chk.sv
module asf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] thresh_code,
    input logic [2:0] level_code,
    input logic       req_flag,
    input logic       overrun,
    input logic       underrun
);

    a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        level_code <= 3'd5);

    a_r2_pair_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code != 3'd0 && wr_en && rd_en && !flush) |=> $stable(level_code));

    a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh_code >= 3'd5) |-> !req_flag);

    a_r7_full_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code == 3'd5 && wr_en && !rd_en && !flush) |=> (level_code == 3'd5 && overrun));

    a_r8_empty_read_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code == 3'd0 && rd_en && !wr_en && !flush) |=> (level_code == 3'd0 && underrun));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level_code == 3'd0 && !overrun && !underrun));

endmodule

bind audio_sample_fifo asf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .thresh_code (thresh_code),
    .level_code  (level_code),
    .req_flag    (req_flag),
    .overrun     (overrun),
    .underrun    (underrun)
);

// File: tb/audio_sample_fifo_tb.sv
`timescale 1ns/1ps
module audio_sample_fifo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  thresh_code = 3'd0;
    logic        irq_en = 1'b0;
    logic        dma_en = 1'b0;
    logic [2:0]  level_code;
    logic        req_flag, irq, dma_req, overrun, underrun;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    audio_sample_fifo #(.DATA_W(32), .DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .thresh_code(thresh_code), .irq_en(irq_en),
        .dma_en(dma_en), .level_code(level_code), .req_flag(req_flag), .irq(irq),
        .dma_req(dma_req), .overrun(overrun), .underrun(underrun)
    );

    // Row layout: [9] wr, [8] rd, [7] flush, [6:4] threshold, [3:1] expected level, [0] expected request
    localparam int NV = 18;
    localparam logic [9:0] VEC [NV] = '{
        10'b000_000_000_1,
        10'b100_001_001_0,
        10'b100_001_010_1,
        10'b100_010_010_0,
        10'b100_010_011_1,
        10'b100_011_011_0,
        10'b100_011_100_1,
        10'b100_100_100_0,
        10'b100_100_101_1,
        10'b110_100_101_1,
        10'b010_100_100_0,
        10'b010_011_100_1,
        10'b010_011_011_0,
        10'b000_101_011_0,
        10'b000_010_011_1,
        10'b001_010_000_0,
        10'b000_000_000_1,
        10'b100_111_001_0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One access: drive at a falling edge, release and leave results to sample at the next one.
    task automatic step(input logic w, input logic r, input logic f, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; flush = f; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        thresh_code = 3'd1; irq_en = 1'b1; dma_en = 1'b1;
        #1;
        check("R10 level", 32'(level_code), 32'd0);
        check("R10 overrun", 32'(overrun), 32'd0);
        check("R10 underrun", 32'(underrun), 32'd0);
        check("R4 quarter on empty", 32'(req_flag), 32'd0);
        dma_en = 1'b0;

        // Table walk: R3 levels, R4 thresholds, R5 reserved codes, R2 paired access, R9 flush, R6 gating
        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            v = VEC[i];
            thresh_code = v[6:4];
            step(v[9], v[8], v[7], 32'h100 + 32'(i));
            check("R3 level", 32'(level_code), 32'(v[3:1]));
            check((v[6:4] >= 3'd5) ? "R5 reserved" : "R4 request", 32'(req_flag), 32'(v[0]));
            check("R6 irq", 32'(irq), 32'(v[0]));
            check("R6 dma off", 32'(dma_req), 32'd0);
        end

        // R1 ordering and R7 overrun
        step(1'b0, 1'b0, 1'b1, '0);
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b0, 32'hA000 + 32'(k));
        step(1'b1, 1'b0, 1'b0, 32'hDEAD);
        check("R7 overrun pulse", 32'(overrun), 32'd1);
        check("R7 level full", 32'(level_code), 32'd5);
        step(1'b0, 1'b0, 1'b0, '0);
        check("R7 single cycle", 32'(overrun), 32'd0);
        for (int k = 0; k < 8; k++) begin
            check("R1 order", rd_data, 32'hA000 + 32'(k));
            step(1'b0, 1'b1, 1'b0, '0);
        end
        check("R2 drained", 32'(level_code), 32'd0);

        // R8 underrun
        step(1'b0, 1'b1, 1'b0, '0);
        check("R8 underrun pulse", 32'(underrun), 32'd1);
        check("R8 level", 32'(level_code), 32'd0);
        step(1'b0, 1'b0, 1'b0, '0);
        check("R8 single cycle", 32'(underrun), 32'd0);
        step(1'b1, 1'b1, 1'b0, 32'hBEEF);
        check("R8 paired underrun", 32'(underrun), 32'd1);
        check("R8 write kept level", 32'(level_code), 32'd1);
        check("R8 write kept data", rd_data, 32'hBEEF);

        // R2 paired access mid-fill
        step(1'b1, 1'b0, 1'b0, 32'hC1);
        step(1'b1, 1'b0, 1'b0, 32'hC2);
        step(1'b1, 1'b1, 1'b0, 32'hC3);
        check("R2 paired level", 32'(level_code), 32'd2);
        check("R2 paired head", rd_data, 32'hC1);

        // R9 flush overrides a write
        step(1'b1, 1'b0, 1'b1, 32'h55);
        check("R9 flush level", 32'(level_code), 32'd0);
        check("R9 no overrun", 32'(overrun), 32'd0);
        step(1'b1, 1'b0, 1'b0, 32'h77);
        check("R9 fresh head", rd_data, 32'h77);
        check("R9 fresh level", 32'(level_code), 32'd1);

        // R6 gating
        step(1'b0, 1'b0, 1'b1, '0);
        thresh_code = 3'd0; irq_en = 1'b0; dma_en = 1'b1;
        #1;
        check("R6 irq gated", 32'(irq), 32'd0);
        check("R6 dma passes", 32'(dma_req), 32'd1);
        irq_en = 1'b1; dma_en = 1'b0;
        #1;
        check("R6 irq passes", 32'(irq), 32'd1);
        check("R6 dma gated", 32'(dma_req), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule